// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex serial port for short links to shift registers and similar parts. It moves one byte at a time, least significant bit first, over a single data line. It also drives a shift clock on a second line, and the link partner uses that clock to time the data.

All timing comes from a free-running machine-cycle sequencer. A machine cycle is 12 clocks, made of six states (S1 to S6), and each state has two phases (P1, then P2). The bit rate is therefore one twelfth of the clock rate.

A byte to send enters through a valid/ready handshake. The port takes the byte only when no transfer is in progress, so `tx_ready` low is the back-pressure signal. A received byte leaves through a second valid/ready handshake. While `rx_valid` is high the byte is held, and no new reception can start. Taking the byte (`rx_valid && rx_ready`) frees the port to receive again when `rx_en` is high. `tx_done` is a plain status flag.

Completion does not use a bit counter. A marker bit travels through the shift register, and the transfer ends when the marker reaches a known position.

Top module: `sio_sync_port`

## Requirements
- R1: Out of reset, the outputs are `tx_ready`=1, `tx_done`=0, `rx_valid`=0, `sclk_o`=1, `sdat_o`=1 and `sdat_oe`=0. The phase index is 0 in the first clock after reset is released and then advances by one each clock, wrapping 11 to 0. The index of state Sn, phase Pm is 2(n-1)+(m-1), so S1P1=0, S3P1=4, S5P2=9, S6P1=10 and S6P2=11.
- R2: A byte is taken in a clock where `tx_valid` and `tx_ready` are both 1. In the next clock `tx_ready` and `tx_done` are both 0. `tx_ready` stays low until the transfer has ended.
- R3: Sending starts at the S6P2 edge that ends the machine cycle after the one in which the byte was taken. At that edge `sdat_oe` rises while the index becomes 0. The eight data bits then appear on `sdat_o`, least significant bit first, each held for one machine cycle. When the port is not sending, `sdat_o` is 1.
- R4: During a transfer, `sclk_o` is low for indices 4 to 9 and high for the other indices. Each transfer gives exactly 8 low pulses. When the port is idle, `sclk_o` is 1.
- R5: A send ends at the S1P1 edge of the 10th machine cycle after the accept cycle, whatever the data value. That edge is 109 clocks after the S6P2 edge that closes the accept cycle. At that edge `tx_done` is set, `sdat_oe` falls and `tx_ready` returns to 1.
- R6: While receiving, the port samples `sdat_i` at the S5P2 edge (index 9) of each of the 8 low shift-clock pulses. The first sample becomes bit 0 of `rx_data`.
- R7: A reception starts in any clock where `rx_en`=1, `rx_valid`=0, the port is idle and `tx_valid`=0. `rx_valid` rises at the S1P1 edge of the 10th machine cycle after that clock.
- R8: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid` and `rx_data` hold, and no reception starts (no shift-clock pulses). One handshake clears `rx_valid`.
- R9: While `rx_en` is 0, no reception starts: `sclk_o` stays high and `rx_valid` stays 0.
- R10: While the port is receiving, `tx_ready` is 0. If a send request and the receive start condition appear in the same idle clock, the send runs first and the reception starts after `tx_done` rises.
- R11: `sdat_oe` is 1 only while the port is sending, and is never 1 during a reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Byte to send is offered |
| tx_data | input | DATA_W (8) | Byte to send |
| tx_ready | output | 1 | Port is idle and can take a byte |
| tx_done | output | 1 | Last send finished; cleared when the next byte is taken |
| rx_en | input | 1 | Allows receptions to start |
| rx_valid | output | 1 | Received byte is held on rx_data |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | DATA_W (8) | Received byte |
| sdat_o | output | 1 | Serial data out |
| sdat_oe | output | 1 | Drive enable for the data line |
| sdat_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Shift clock |

## Verification
A send request and a receive start can fall in the same idle clock. Both paths then compete for the one data line and the one shift clock. The bench provokes this by raising `tx_valid` and `rx_en` on the same edge while `rx_valid` is clear. It judges the outcome in three ways:
- `tx_ready` must fall.
- The data line must be driven at every shift-clock pulse of the first transfer, and it must carry the offered byte.
- The byte returned by the bench's emulated partner must arrive only in the transfer that follows.

A second case exercises back-pressure. A full receive buffer must block the next reception until the consumer takes the byte.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Machine cycle: 6 states x 2 phases.
  localparam int PH_CNT = 12;
  localparam int PH_W   = $clog2(PH_CNT);

  typedef logic [PH_W-1:0] phase_t;

  // Phase index = 2*(state-1) + (phase-1).
  localparam phase_t PH_S1P1 = phase_t'(0);
  localparam phase_t PH_S3P1 = phase_t'(4);
  localparam phase_t PH_S5P2 = phase_t'(9);
  localparam phase_t PH_S6P1 = phase_t'(10);
  localparam phase_t PH_S6P2 = phase_t'(11);

  // Per-direction transfer state.
  typedef enum logic [1:0] {
    LANE_IDLE,
    LANE_ARM,
    LANE_RUN,
    LANE_FIN
  } lane_t;

endpackage

// File: rtl/sio_phase_seq.sv
module sio_phase_seq
  import sio_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase,
  output logic   at_s1p1,
  output logic   at_s5p2,
  output logic   at_s6p2,
  output logic   low_win
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == PH_S6P2) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign at_s1p1 = (phase == PH_S1P1);
  assign at_s5p2 = (phase == PH_S5P2);
  assign at_s6p2 = (phase == PH_S6P2);
  // Shift clock is low from S3P1 up to, not including, S6P1.
  assign low_win = (phase >= PH_S3P1) && (phase < PH_S6P1);

endmodule

// File: rtl/sio_tx_lane.sv
module sio_tx_lane
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  input  logic              at_s1p1,
  input  logic              at_s6p2,
  output logic              busy,
  output logic              sending,
  output logic              bit_o,
  output logic              done
);

  localparam int SR_W = DATA_W + 1;

  lane_t           st;
  logic [SR_W-1:0] sr;
  logic            wait_more;
  logic            marker_next;

  // Marker sits just left of the MSB and everything above it is zero.
  assign marker_next = (sr[SR_W-1:2] == '0) && sr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LANE_IDLE;
      sr        <= '0;
      wait_more <= 1'b0;
    end else begin
      case (st)
        LANE_IDLE: begin
          if (go) begin
            sr        <= {1'b1, data};
            wait_more <= !at_s6p2;
            st        <= LANE_ARM;
          end
        end
        LANE_ARM: begin
          if (at_s6p2) begin
            if (wait_more) begin
              wait_more <= 1'b0;
            end else begin
              st <= LANE_RUN;
            end
          end
        end
        LANE_RUN: begin
          if (at_s6p2) begin
            sr <= {1'b0, sr[SR_W-1:1]};
            if (marker_next) begin
              st <= LANE_FIN;
            end
          end
        end
        LANE_FIN: begin
          if (at_s1p1) begin
            st <= LANE_IDLE;
          end
        end
        default: st <= LANE_IDLE;
      endcase
    end
  end

  assign busy    = (st != LANE_IDLE);
  assign sending = (st == LANE_RUN) || (st == LANE_FIN);
  assign bit_o   = sr[0];
  assign done    = (st == LANE_FIN) && at_s1p1;

endmodule

// File: rtl/sio_rx_lane.sv
module sio_rx_lane
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              din,
  input  logic              at_s1p1,
  input  logic              at_s5p2,
  input  logic              at_s6p2,
  output logic              busy,
  output logic              receiving,
  output logic              done,
  output logic [DATA_W-1:0] byte_o
);

  lane_t             st;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] nxt;
  logic [DATA_W-1:0] rev;
  logic              wait_more;
  logic              samp;

  assign nxt = {sr[DATA_W-2:0], samp};

  // First bit in lands at the left end; reverse so it becomes bit 0.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev[i] = nxt[DATA_W-1-i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= 1'b1;
    end else if (at_s5p2 && (st == LANE_RUN)) begin
      samp <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LANE_IDLE;
      sr        <= '1;
      wait_more <= 1'b0;
      byte_o    <= '0;
    end else begin
      case (st)
        LANE_IDLE: begin
          if (go) begin
            wait_more <= !at_s6p2;
            st        <= LANE_ARM;
          end
        end
        LANE_ARM: begin
          if (at_s6p2) begin
            if (wait_more) begin
              wait_more <= 1'b0;
            end else begin
              sr <= {{(DATA_W-1){1'b1}}, 1'b0};
              st <= LANE_RUN;
            end
          end
        end
        LANE_RUN: begin
          if (at_s6p2) begin
            sr <= nxt;
            if (!sr[DATA_W-1]) begin
              byte_o <= rev;
              st     <= LANE_FIN;
            end
          end
        end
        LANE_FIN: begin
          if (at_s1p1) begin
            st <= LANE_IDLE;
          end
        end
        default: st <= LANE_IDLE;
      endcase
    end
  end

  assign busy      = (st != LANE_IDLE);
  assign receiving = (st == LANE_RUN) || (st == LANE_FIN);
  assign done      = (st == LANE_FIN) && at_s1p1;

endmodule

// File: rtl/sio_sync_port.sv
module sio_sync_port
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_done,
  input  logic              rx_en,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              sdat_o,
  output logic              sdat_oe,
  input  logic              sdat_i,
  output logic              sclk_o
);

  phase_t phase;
  logic   at_s1p1;
  logic   at_s5p2;
  logic   at_s6p2;
  logic   low_win;
  logic   tx_busy;
  logic   tx_sending;
  logic   tx_bit;
  logic   tx_fin;
  logic   rx_busy;
  logic   rx_receiving;
  logic   rx_fin;
  logic   port_idle;
  logic   tx_go;
  logic   rx_go;

  sio_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .at_s1p1 (at_s1p1),
    .at_s5p2 (at_s5p2),
    .at_s6p2 (at_s6p2),
    .low_win (low_win)
  );

  assign port_idle = !tx_busy && !rx_busy;
  assign tx_go     = tx_valid && port_idle;
  // The send path takes precedence when both ask in the same idle clock.
  assign rx_go     = rx_en && !rx_valid && port_idle && !tx_valid;

  sio_tx_lane #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (tx_go),
    .data    (tx_data),
    .at_s1p1 (at_s1p1),
    .at_s6p2 (at_s6p2),
    .busy    (tx_busy),
    .sending (tx_sending),
    .bit_o   (tx_bit),
    .done    (tx_fin)
  );

  sio_rx_lane #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (rx_go),
    .din       (sdat_i),
    .at_s1p1   (at_s1p1),
    .at_s5p2   (at_s5p2),
    .at_s6p2   (at_s6p2),
    .busy      (rx_busy),
    .receiving (rx_receiving),
    .done      (rx_fin),
    .byte_o    (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
    end else if (tx_go) begin
      tx_done <= 1'b0;
    end else if (tx_fin) begin
      tx_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
    end else if (rx_fin) begin
      rx_valid <= 1'b1;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  assign tx_ready = port_idle;
  assign sclk_o   = !((tx_sending || rx_receiving) && low_win);
  assign sdat_oe  = tx_sending;
  assign sdat_o   = tx_sending ? tx_bit : 1'b1;

endmodule

// File: rtl/sio_sync_port_chk.sv
module sio_sync_port_chk
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input phase_t            phase,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_done,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              sdat_oe,
  input logic              sclk_o
);

  // R4
  sclk_low_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_o |-> (phase >= PH_S3P1 && phase <= PH_S5P2));

  // R11
  oe_only_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdat_oe |-> !tx_ready);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R7
  rx_flag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> (phase == phase_t'(1)));

  // R5
  tx_flag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (phase == phase_t'(1)));

  // R2
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!tx_ready && !tx_done));

  // R3
  send_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdat_oe) |-> (phase == PH_S1P1));

endmodule

bind sio_sync_port sio_sync_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_done  (tx_done),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .rx_data  (rx_data),
  .sdat_oe  (sdat_oe),
  .sclk_o   (sclk_o)
);

// File: tb/test_sio_sync_port.sv
module test_sio_sync_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic       tx_done;
  logic       rx_en = 1'b0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       sdat_o;
  logic       sdat_oe;
  logic       sdat_i = 1'b1;
  logic       sclk_o;

  int checks = 0;
  int fails  = 0;
  int ph     = 0;

  always #2 clk = ~clk;

  sio_sync_port i_sio_sync_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .tx_done  (tx_done),
    .rx_en    (rx_en),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .sdat_o   (sdat_o),
    .sdat_oe  (sdat_oe),
    .sdat_i   (sdat_i),
    .sclk_o   (sclk_o)
  );

  // Bench model of the phase index from R1.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 0;
    else        ph <= (ph == 11) ? 0 : ph + 1;
  end

  // {is_tx, accept phase, data}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 4'd11, 8'hA5},
    {1'b1, 4'd0,  8'h00},
    {1'b1, 4'd5,  8'hFF},
    {1'b0, 4'd11, 8'h3C},
    {1'b0, 4'd0,  8'h81},
    {1'b1, 4'd10, 8'h01},
    {1'b0, 4'd3,  8'hFF},
    {1'b0, 4'd7,  8'h00}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs from a negedge until the done flag of the chosen direction is seen.
  task automatic serve(input bit is_tx, input logic [7:0] d,
                       output int n, output int nb, output logic [7:0] got);
    logic prev;
    bit   seen;
    n = 0; nb = 0; got = '0; prev = sclk_o; seen = 0;
    while (!seen && n < 400) begin
      if (prev && !sclk_o) begin
        if (nb < 8) begin
          if (is_tx) begin
            got[nb] = sdat_o;
            chk(sdat_oe == 1'b1, "R11 line driven while sending", sdat_oe, 1);
          end else begin
            sdat_i = d[nb];
            chk(sdat_oe == 1'b0, "R11 line released while receiving", sdat_oe, 0);
            chk(tx_ready == 1'b0, "R10 tx blocked while receiving", tx_ready, 0);
          end
        end
        nb++;
      end
      prev = sclk_o;
      if (is_tx ? tx_done : rx_valid) begin
        seen = 1;
      end else begin
        @(negedge clk);
        n++;
      end
    end
    if (!seen) chk(1'b0, "R5 R7 transfer never finished", n, 0);
  endtask

  task automatic do_xfer(input bit is_tx, input logic [7:0] d, input int tph);
    int n;
    int nb;
    logic [7:0] got;
    while (ph != tph) @(negedge clk);
    if (is_tx) begin
      chk(tx_ready == 1'b1, "R2 ready before offer", tx_ready, 1);
      tx_valid = 1'b1;
      tx_data  = d;
    end else begin
      rx_en = 1'b1;
    end
    @(negedge clk);
    tx_valid = 1'b0;
    rx_en    = 1'b0;
    if (is_tx) chk(!tx_ready && !tx_done, "R2 busy after accept", {tx_ready, tx_done}, 0);
    serve(is_tx, d, n, nb, got);
    chk(nb == 8, "R4 shift clock pulse count", nb, 8);
    if (is_tx) begin
      chk(n == 120 - tph, "R5 tx_done timing", n, 120 - tph);
      chk(got == d, "R3 serial bits LSB first", got, d);
      chk(tx_ready && !sdat_oe && sdat_o, "R5 line released", {tx_ready, sdat_oe, sdat_o}, 3'b101);
    end else begin
      chk(n == 120 - tph, "R7 rx_valid timing", n, 120 - tph);
      chk(rx_data == d, "R6 received byte", rx_data, d);
      rx_ready = 1'b1;
      @(negedge clk);
      rx_ready = 1'b0;
      chk(!rx_valid, "R8 handshake clears rx_valid", rx_valid, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired (R1 to R11 incomplete) actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int nb;
    int falls;
    logic [7:0] got;
    logic [7:0] held;
    logic prev;

    repeat (3) @(negedge clk);
    // R1: values held in reset
    chk(tx_ready && !tx_done && !rx_valid, "R1 reset flags",
        {tx_ready, tx_done, rx_valid}, 3'b100);
    chk(sclk_o && sdat_o && !sdat_oe, "R1 reset lines",
        {sclk_o, sdat_o, sdat_oe}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_o && sdat_o && !sdat_oe && tx_ready, "R1 idle after release",
        {sclk_o, sdat_o, sdat_oe, tx_ready}, 4'b1101);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      do_xfer(VEC[i][12], VEC[i][7:0], int'(VEC[i][11:8]));
    end

    // R9: receive disabled, nothing happens
    rx_en = 1'b0;
    falls = 0;
    prev  = sclk_o;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (prev && !sclk_o) falls++;
      prev = sclk_o;
    end
    chk(falls == 0 && !rx_valid, "R9 no reception when disabled", falls, 0);

    // R10: send request and receive start in the same idle clock
    tx_valid = 1'b1;
    tx_data  = 8'hC3;
    rx_en    = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!tx_ready, "R10 send taken on collision", tx_ready, 0);
    serve(1'b1, 8'hC3, n, nb, got);
    chk(got == 8'hC3 && nb == 8, "R10 send goes first", got, 8'hC3);
    serve(1'b0, 8'h96, n, nb, got);
    chk(rx_valid && rx_data == 8'h96, "R10 reception follows send", rx_data, 8'h96);

    // R8: full buffer blocks a new reception while rx_en stays high
    held  = rx_data;
    falls = 0;
    prev  = sclk_o;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (prev && !sclk_o) falls++;
      prev = sclk_o;
    end
    chk(falls == 0, "R8 no pulses while buffer full", falls, 0);
    chk(rx_valid && rx_data == held, "R8 byte held", rx_data, held);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(!rx_valid, "R8 handshake clears flag", rx_valid, 0);
    serve(1'b0, 8'h5A, n, nb, got);
    chk(rx_valid && rx_data == 8'h5A && nb == 8, "R8 next reception after take", rx_data, 8'h5A);
    rx_en    = 1'b0;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk(!rx_valid && tx_ready, "R8 port idle after final take", {rx_valid, tx_ready}, 2'b01);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule